// File: doc/BRIEF.md
# Streaming Sobel Edge Binarizer

This block accepts 8-bit grayscale pixels in raster order, one pixel on each cycle where the input valid is high, and returns one black-or-white pixel for every pixel it accepts. Two earlier image rows are kept in on-chip line buffers. For each new pixel, a 3x3 neighbourhood is formed whose newest (bottom-right) sample is that pixel. The horizontal and vertical Sobel gradients of that neighbourhood are summed as absolute values and clipped to 255. The result is then compared with a fixed threshold. Strong edges come out as 255 and everything else as 0.

Frame width, frame height and the threshold are parameters, with defaults of 64x48 and 45. A start-of-frame flag that comes with a valid pixel marks that pixel as row 0, column 0. Without that flag, the position wraps to the next frame by itself after the last pixel of the last row. Where the neighbourhood reaches above row 0 or left of column 0, the nearest pixel of row 0 or column 0 is used in its place. Input beats may have idle cycles between them, and the output follows the same pattern of idle cycles, two cycles later.

Top module: `sobel_edge_bin`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, outValid is 0 and outPix is 0.
- R2: Each cycle with inValid high gives exactly one cycle with outValid high two clock edges later. No other cycle has outValid high.
- R3: Whenever outValid is high, outPix is either 0 or 255.
- R4: The pixel position advances in raster order, one column per accepted pixel. After column WIDTH-1 the column returns to 0 and the row steps by one. After the last column of row HEIGHT-1 the position wraps to row 0, column 0.
- R5: When inSof is high with inValid, that pixel is row 0, column 0. When inSof is high with inValid low, it has no effect on the position.
- R6: The output for the input pixel at (row y, column x) is computed over input rows y-2..y and columns x-2..x.
- R7: With window rows top to bottom and columns left to right, Gx = (right column weighted 1,2,1) minus (left column weighted 1,2,1), and Gy = (bottom row weighted 1,2,1) minus (top row weighted 1,2,1). The magnitude is |Gx|+|Gy|, clipped at 255.
- R8: outPix is 255 when the magnitude is strictly greater than THRESH (default 45). It is 0 when the magnitude equals or is below THRESH.
- R9: A row index below 0 is replaced by row 0, and a column index below 0 by column 0. This covers the first two rows and the first two columns of each frame.
- R10: Cycles with inValid low do not advance the position and do not change the stored rows or columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A pixel is presented on inPix this cycle |
| inSof | input | 1 | With inValid: this pixel starts a frame |
| inPix | input | 8 | Grayscale input pixel |
| outValid | output | 1 | outPix holds a result this cycle |
| outPix | output | 8 | Binarized edge pixel, 0 or 255 |

## Verification
The hardest case to reach from the ports is the threshold boundary: magnitudes of exactly 45 and 46 occur only rarely in a full-range random image. The bench therefore runs one frame with low-amplitude random pixels, where gradients cluster around the threshold. A partial frame cut short by a fresh start-of-frame covers restart while the line buffers still hold stale rows. A gapped frame with stray start flags on idle cycles covers R5 and R10. Every output is compared with a bench model that applies clamped indexing to a stored copy of the image.

// File: rtl/sobel_bin_pkg.sv
package sobel_bin_pkg;

  // Strobes from the position control to the window datapath
  typedef struct packed {
    logic advance;    // a pixel is accepted this cycle
    logic rowFirst;   // current pixel lies in row 0
    logic rowSecond;  // current pixel lies in row 1
    logic colFirst;   // current pixel lies in column 0
    logic colSecond;  // current pixel lies in column 1
  } winCtl_t;

  // One vertical slice of the window: [0] top, [1] middle, [2] bottom
  typedef logic [2:0][7:0] pixCol_t;

endpackage

// File: rtl/sobel_bin_ctrl.sv
module sobel_bin_ctrl
  import sobel_bin_pkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int HEIGHT = 48,
  localparam int CW = (WIDTH  > 1) ? $clog2(WIDTH)  : 1,
  localparam int RW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inSof,
  output winCtl_t       ctl,
  output logic [CW-1:0] colIdx
);

  logic [CW-1:0] colCnt, curCol;
  logic [RW-1:0] rowCnt, curRow;

  // A start flag with a valid pixel forces this beat to (0,0)
  always_comb begin
    curCol = (inValid && inSof) ? '0 : colCnt;
    curRow = (inValid && inSof) ? '0 : rowCnt;
    colIdx = curCol;
    ctl.advance   = inValid;
    ctl.rowFirst  = (curRow == RW'(0));
    ctl.rowSecond = (curRow == RW'(1));
    ctl.colFirst  = (curCol == CW'(0));
    ctl.colSecond = (curCol == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (inValid) begin
      if (curCol == CW'(WIDTH - 1)) begin
        colCnt <= '0;
        rowCnt <= (curRow == RW'(HEIGHT - 1)) ? '0 : curRow + RW'(1);
      end else begin
        colCnt <= curCol + CW'(1);
        rowCnt <= curRow;
      end
    end
  end

  a_r4_col_range: assert property (@(posedge clk) disable iff (rst)
    (int'(colCnt) < WIDTH) && (int'(rowCnt) < HEIGHT));

  a_r4_row_step: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inSof && int'(colCnt) == WIDTH - 1 && int'(rowCnt) != HEIGHT - 1)
    |=> (colCnt == '0 && rowCnt == $past(rowCnt) + RW'(1)));

  a_r5_sof_restart: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSof) |=> (colCnt == CW'(1) && rowCnt == '0));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(colCnt) && $stable(rowCnt)));

endmodule

// File: rtl/sobel_bin_datapath.sv
module sobel_bin_datapath
  import sobel_bin_pkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int THRESH = 45,
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    inPix,
  input  winCtl_t       ctl,
  input  logic [CW-1:0] colIdx,
  output logic          outValid,
  output logic [7:0]    outPix
);

  // Line storage: lineA holds the row above, lineB the row above that
  logic [7:0] lineA [WIDTH];
  logic [7:0] lineB [WIDTH];
  logic [7:0] rdA, rdB, midPix, topPix;
  pixCol_t    curSlice, histNear, histFar;
  pixCol_t    nxtL, nxtM;
  pixCol_t    winL, winM, winR;
  logic       s1Valid;

  always_comb begin
    rdA    = lineA[colIdx];
    rdB    = lineB[colIdx];
    midPix = ctl.rowFirst ? inPix : rdA;
    topPix = (ctl.rowFirst || ctl.rowSecond) ? midPix : rdB;
    curSlice = {inPix, midPix, topPix};
    nxtM = ctl.colFirst ? curSlice : histNear;
    nxtL = ctl.colFirst ? curSlice : (ctl.colSecond ? histNear : histFar);
  end

  always_ff @(posedge clk) begin
    if (ctl.advance) begin
      lineA[colIdx] <= inPix;
      lineB[colIdx] <= rdA;
    end
  end

  // Stage 1: register the 3x3 window
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      histNear <= '0;
      histFar  <= '0;
      winL     <= '0;
      winM     <= '0;
      winR     <= '0;
    end else begin
      s1Valid <= ctl.advance;
      if (ctl.advance) begin
        histNear <= curSlice;
        histFar  <= histNear;
        winL     <= nxtL;
        winM     <= nxtM;
        winR     <= curSlice;
      end
    end
  end

  function automatic logic [9:0] weigh(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    return 10'(a) + {1'b0, b, 1'b0} + 10'(c);
  endfunction

  function automatic logic [9:0] absDiff(logic [9:0] p, logic [9:0] q);
    return (p >= q) ? p - q : q - p;
  endfunction

  // Stage 2: gradients, magnitude, saturation, inverted compare and mux
  logic [9:0]  absX, absY;
  logic [10:0] magSum;
  logic [7:0]  satMag;
  logic        notEdge;

  always_comb begin
    absX    = absDiff(weigh(winR[0], winR[1], winR[2]), weigh(winL[0], winL[1], winL[2]));
    absY    = absDiff(weigh(winL[2], winM[2], winR[2]), weigh(winL[0], winM[0], winR[0]));
    magSum  = {1'b0, absX} + {1'b0, absY};
    satMag  = (magSum > 11'd255) ? 8'hFF : magSum[7:0];
    notEdge = !(int'(satMag) > THRESH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outPix   <= 8'h00;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) outPix <= notEdge ? 8'h00 : 8'hFF;
    end
  end

  a_r3_binary_out: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outPix == 8'h00 || outPix == 8'hFF));

  a_r2_stage_follow: assert property (@(posedge clk) disable iff (rst)
    s1Valid |=> outValid);

endmodule

// File: rtl/sobel_edge_bin.sv
module sobel_edge_bin
  import sobel_bin_pkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int HEIGHT = 48,
  parameter int THRESH = 45
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inSof,
  input  logic [7:0] inPix,
  output logic       outValid,
  output logic [7:0] outPix
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  winCtl_t       ctl;
  logic [CW-1:0] colIdx;

  sobel_bin_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof),
    .ctl(ctl), .colIdx(colIdx)
  );

  sobel_bin_datapath #(.WIDTH(WIDTH), .THRESH(THRESH)) u_dp (
    .clk(clk), .rst(rst), .inPix(inPix), .ctl(ctl), .colIdx(colIdx),
    .outValid(outValid), .outPix(outPix)
  );

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

endmodule

// File: tb/sobel_edge_bin_bench.sv
module sobel_edge_bin_bench;

  localparam int W  = 64;
  localparam int H  = 48;
  localparam int TH = 45;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       inSof = 1'b0;
  logic [7:0] inPix = 8'h00;
  logic       outValid;
  logic [7:0] outPix;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sobel_edge_bin #(.WIDTH(W), .HEIGHT(H), .THRESH(TH)) u_sobel_edge_bin (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .outValid(outValid), .outPix(outPix)
  );

  // Bench model state
  int    img [H][W];
  int    refRow = 0, refCol = 0;
  int    expQ [$];
  string tagQ [$];
  bit    vHist0 = 1'b0, vHist1 = 1'b0;
  string phaseTag = "R6";
  int    nearHits = 0;

  function automatic int clampPix(int r, int c);
    return img[(r < 0) ? 0 : r][(c < 0) ? 0 : c];
  endfunction

  // R7 magnitude over the R6 window with R9 clamping
  function automatic int refMag(int r, int c);
    int w [3][3];
    int gx, gy, m;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        w[i][j] = clampPix(r - 2 + i, c - 2 + j);
    gx = (w[0][2] + 2*w[1][2] + w[2][2]) - (w[0][0] + 2*w[1][0] + w[2][0]);
    gy = (w[2][0] + 2*w[2][1] + w[2][2]) - (w[0][0] + 2*w[0][1] + w[0][2]);
    m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (m > 255) ? 255 : m;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Sample outputs, then drive one cycle of inputs
  task automatic step(bit v, bit s, int p);
    @(negedge clk);
    check(outValid == vHist1, "R2 outValid timing", int'(outValid), int'(vHist1));
    if (outValid) begin
      int e;
      string t;
      check(outPix == 8'h00 || outPix == 8'hFF, "R3 binary value", int'(outPix), 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", int'(outPix), -1);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(outPix) == e, t, int'(outPix), e);
      end
    end
    vHist1 = vHist0;
    vHist0 = v;
    inValid = v;
    inSof = s;
    inPix = 8'(p);
    if (v) begin
      int m;
      string pos;
      if (s) begin refRow = 0; refCol = 0; end
      img[refRow][refCol] = p;
      m = refMag(refRow, refCol);
      if (refRow < 2 || refCol < 2) pos = "R9 border";
      else if (m == TH || m == TH + 1) begin pos = "R8 threshold edge"; nearHits++; end
      else pos = "R7 magnitude";
      expQ.push_back((m > TH) ? 255 : 0);
      tagQ.push_back($sformatf("%s %s at (%0d,%0d) mag=%0d", phaseTag, pos, refRow, refCol, m));
      if (refCol == W - 1) begin
        refCol = 0;
        refRow = (refRow == H - 1) ? 0 : refRow + 1;
      end else refCol++;
    end
  endtask

  task automatic runFrame(bit withSof, int maxVal, int gapPct, int count);
    int sent = 0;
    while (sent < count) begin
      if (gapPct > 0 && ($urandom % 100) < gapPct) begin
        step(1'b0, ($urandom % 4) == 0, $urandom % 256);  // R5 stray start ignored, R10 idle
      end else begin
        step(1'b1, withSof && sent == 0, $urandom % (maxVal + 1));
        sent++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(outPix == 8'h00, "R1 reset outPix", int'(outPix), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && outPix == 8'h00, "R1 after reset", int'(outPix), 0);

    phaseTag = "R6";  // full-range random frame
    runFrame(1'b1, 255, 0, W * H);
    phaseTag = "R4";  // no start flag: relies on wrap; low amplitude near threshold
    runFrame(1'b0, 24, 0, W * H);
    phaseTag = "R10"; // idle gaps with stray start flags
    runFrame(1'b1, 255, 30, W * H);
    phaseTag = "R5";  // cut short, then restarted
    runFrame(1'b1, 40, 0, 200);
    runFrame(1'b1, 30, 10, W * H);
    repeat (4) step(1'b0, 1'b0, 0);
    check(expQ.size() == 0, "R2 outputs outstanding", expQ.size(), 0);
    check(nearHits > 0, "R8 threshold neighbourhood reached", nearHits, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule